// File: doc/BRIEF.md
# Channel-Interleave Address Dehasher

Memory controllers that spread traffic over several channels often scramble the channel-select bits of a physical address. Each select bit is XORed with higher address bits so that strided access patterns still reach every channel. This block reverses that scrambling. It takes a hashed address together with its interleave configuration and returns the address with the channel-select bits restored to their original values.

The configuration consists of three things:
- three enables for the 64 KiB, 2 MiB and 1 GiB hash terms;
- the total number of interleaved channels (2, 4, 8 or 16);
- a flag that marks a single-socket system.

Up to four correction stages run in a fixed order, and each stage works on the address produced by the stage before it. The channel count decides how many stages take effect. A configuration with an illegal channel count is flagged as an error, and its address is returned untouched.

Transactions enter through a valid/ready handshake. The corrected address appears one clock later in a registered output. That output is held stable while the consumer stalls it.

Top module: `chan_dehash`

## Requirements
- R1: Stage 1 replaces address bit 8 with bit 8 XOR (bit 16 AND en_64k) XOR (bit 21 AND en_2m) XOR (bit 30 AND en_1g). It runs for every legal channel count.
- R2: When one_socket_i is 1, stage 1 also XORs in address bit 14. This is the value of bit 14 at the input, taken before any later stage changes it.
- R3: When the channel count is greater than 2, bit 12 is replaced by bit 12 XOR (bit 17 AND en_64k) XOR (bit 22 AND en_2m) XOR (bit 31 AND en_1g). Otherwise bit 12 is unchanged.
- R4: When the channel count is greater than 4, bit 13 is replaced by bit 13 XOR (bit 18 AND en_64k) XOR (bit 23 AND en_2m) XOR (bit 32 AND en_1g). Otherwise bit 13 is unchanged.
- R5: When the channel count is greater than 8, bit 14 is replaced by bit 14 XOR (bit 19 AND en_64k) XOR (bit 24 AND en_2m) XOR (bit 33 AND en_1g). With 8 or fewer channels, bit 14 is unchanged.
- R6: Every address bit other than 8, 12, 13 and 14 passes to the output unchanged.
- R7: A channel count other than 2, 4, 8 or 16 sets err_o with the result, and the output address equals the input address.
- R8: An input is accepted on a clock edge where in_valid_i and in_ready_o are both 1. Its result appears on out_addr_o with out_valid_o = 1 after exactly one clock.
- R9: in_ready_o is 1 whenever out_valid_o is 0 or out_ready_i is 1. While out_valid_o is 1 and out_ready_i is 0, out_valid_o, out_addr_o and err_o hold their values.
- R10: While rst_ni is low, out_valid_o and err_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input transaction valid |
| in_ready_o | output | 1 | Block can accept an input |
| addr_i | input | 52 | Hashed physical address |
| en_64k_i | input | 1 | Enable 64 KiB hash terms |
| en_2m_i | input | 1 | Enable 2 MiB hash terms |
| en_1g_i | input | 1 | Enable 1 GiB hash terms |
| chan_cnt_i | input | 5 | Total interleaved channel count |
| one_socket_i | input | 1 | Single-socket system, adds the bit 14 term to stage 1 |
| out_valid_o | output | 1 | Result valid |
| out_ready_i | input | 1 | Consumer accepts the result |
| out_addr_o | output | 52 | Dehashed address |
| err_o | output | 1 | Illegal channel count for this result |

## Verification
The assertions check the following on every cycle:
- the handshake timing;
- that results hold stable during a stall;
- that all untargeted bits pass through unchanged;
- that bit 14 is untouched with eight or fewer channels;
- that an illegal channel count yields an error together with the unmodified address.

The exact value of each corrected bit, and the ordering effect on bit 14, are shown only by the bench. In stage 1 the single-socket term reads bit 14 before stage 4 rewrites it, and the bench's reference model exposes this when it is compared against the design over directed and random configurations.

// File: rtl/dehash_pkg.sv
package dehash_pkg;
  localparam int ADDR_W   = 52;
  localparam int N_STAGES = 4;
  localparam int MAX_CHAN = 1 << N_STAGES;
  localparam int CNT_W    = $clog2(MAX_CHAN) + 1;
  localparam int XTRA_BIT = 14;

  // Bit that stage s restores
  function automatic int tgt_bit(int s);
    return (s == 0) ? 8 : 11 + s;
  endfunction

  function automatic int b64_bit(int s);
    return 16 + s;
  endfunction

  function automatic int b2m_bit(int s);
    return 21 + s;
  endfunction

  function automatic int b1g_bit(int s);
    return 30 + s;
  endfunction

  typedef struct packed {
    logic en_64k;
    logic en_2m;
    logic en_1g;
  } hash_en_t;
endpackage

// File: rtl/dehash_cfg_decode.sv
module dehash_cfg_decode
  import dehash_pkg::*;
#(
  parameter int NS = N_STAGES,
  parameter int CW = CNT_W
) (
  input  logic [CW-1:0] chan_cnt_i,
  output logic          cfg_ok_o,
  output logic [NS-1:0] stage_en_o
);
  localparam int MAXC = 1 << NS;

  logic pow2;
  assign pow2 = (chan_cnt_i != '0) && ((chan_cnt_i & (chan_cnt_i - 1'b1)) == '0);
  assign cfg_ok_o = pow2 && (int'(chan_cnt_i) >= 2) && (int'(chan_cnt_i) <= MAXC);

  for (genvar s = 0; s < NS; s++) begin : g_en
    assign stage_en_o[s] = cfg_ok_o && (int'(chan_cnt_i) > (1 << s));
  end
endmodule

// File: rtl/dehash_stage.sv
module dehash_stage
  import dehash_pkg::*;
#(
  parameter int AW   = ADDR_W,
  parameter int TGT  = 8,
  parameter int B64  = 16,
  parameter int B2M  = 21,
  parameter int B1G  = 30,
  parameter int XTRA = XTRA_BIT
) (
  input  logic [AW-1:0] addr_i,
  input  logic          en_i,
  input  hash_en_t      hen_i,
  input  logic          xtra_i,
  output logic [AW-1:0] addr_o
);
  logic hash;

  always_comb begin
    hash = (addr_i[B64] & hen_i.en_64k)
         ^ (addr_i[B2M] & hen_i.en_2m)
         ^ (addr_i[B1G] & hen_i.en_1g)
         ^ (addr_i[XTRA] & xtra_i);
    addr_o      = addr_i;
    addr_o[TGT] = addr_i[TGT] ^ (en_i & hash);
  end
endmodule

// File: rtl/chan_dehash.sv
module chan_dehash
  import dehash_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int NS = N_STAGES,
  parameter int CW = CNT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  output logic          in_ready_o,
  input  logic [AW-1:0] addr_i,
  input  logic          en_64k_i,
  input  logic          en_2m_i,
  input  logic          en_1g_i,
  input  logic [CW-1:0] chan_cnt_i,
  input  logic          one_socket_i,
  output logic          out_valid_o,
  input  logic          out_ready_i,
  output logic [AW-1:0] out_addr_o,
  output logic          err_o
);
  hash_en_t        hen;
  logic            cfg_ok;
  logic [NS-1:0]   stage_en;
  logic [AW-1:0]   chain [NS+1];
  logic            accept;
  logic            out_valid_q, err_q;
  logic [AW-1:0]   out_addr_q;

  assign hen = '{en_64k: en_64k_i, en_2m: en_2m_i, en_1g: en_1g_i};

  dehash_cfg_decode #(.NS(NS), .CW(CW)) u_cfg (
    .chan_cnt_i (chan_cnt_i),
    .cfg_ok_o   (cfg_ok),
    .stage_en_o (stage_en)
  );

  assign chain[0] = addr_i;

  // Stages in fixed order; stage 0 reads bit 14 before the last stage rewrites it
  for (genvar s = 0; s < NS; s++) begin : g_stage
    dehash_stage #(
      .AW  (AW),
      .TGT (tgt_bit(s)),
      .B64 (b64_bit(s)),
      .B2M (b2m_bit(s)),
      .B1G (b1g_bit(s)),
      .XTRA(XTRA_BIT)
    ) u_stage (
      .addr_i (chain[s]),
      .en_i   (stage_en[s]),
      .hen_i  (hen),
      .xtra_i ((s == 0) ? one_socket_i : 1'b0),
      .addr_o (chain[s+1])
    );
  end

  assign in_ready_o = !out_valid_q || out_ready_i;
  assign accept     = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_q <= 1'b0;
      out_addr_q  <= '0;
      err_q       <= 1'b0;
    end else if (accept) begin
      out_valid_q <= 1'b1;
      out_addr_q  <= cfg_ok ? chain[NS] : addr_i;
      err_q       <= !cfg_ok;
    end else if (out_ready_i) begin
      out_valid_q <= 1'b0;
    end
  end

  assign out_valid_o = out_valid_q;
  assign out_addr_o  = out_addr_q;
  assign err_o       = err_q;

  localparam logic [AW-1:0] TGT_MASK = (AW'(1) << 8) | (AW'(1) << 12)
                                     | (AW'(1) << 13) | (AW'(1) << 14);

  p_latency_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> out_valid_o);

  p_ready_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> in_ready_o);

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=>
      (out_valid_o && $stable(out_addr_o) && $stable(err_o)));

  p_passthru_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=>
      ((out_addr_o & ~TGT_MASK) == ($past(addr_i) & ~TGT_MASK)));

  p_bit14_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o && (chan_cnt_i <= CW'(8))) |=>
      (out_addr_o[14] == $past(addr_i[14])));

  p_err_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o && (($countones(chan_cnt_i) != 1) || (chan_cnt_i < CW'(2)))) |=>
      (err_o && (out_addr_o == $past(addr_i))));
endmodule

// File: tb/chan_dehash_tb.sv
module chan_dehash_tb;
  localparam int AW = 52;
  localparam int CW = 5;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          in_valid = 1'b0, in_ready;
  logic [AW-1:0] addr = '0;
  logic          e64 = 1'b0, e2m = 1'b0, e1g = 1'b0, sock = 1'b0;
  logic [CW-1:0] cnt = 5'd2;
  logic          out_valid, out_ready = 1'b1, err;
  logic [AW-1:0] out_addr;

  int checks = 0, errors = 0;
  string tag = "R10";

  always #2.5 clk = ~clk;

  chan_dehash u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .addr_i(addr), .en_64k_i(e64), .en_2m_i(e2m), .en_1g_i(e1g),
    .chan_cnt_i(cnt), .one_socket_i(sock), .out_valid_o(out_valid),
    .out_ready_i(out_ready), .out_addr_o(out_addr), .err_o(err)
  );

  // Behavioural reference: sequential bit corrections
  function automatic logic [AW-1:0] ref_fn(input logic [AW-1:0] a_in, input logic f64,
      input logic f2m, input logic f1g, input int n, input logic one, output logic bad);
    logic [AW-1:0] a = a_in;
    bad = !(n == 2 || n == 4 || n == 8 || n == 16);
    if (bad) return a_in;
    for (int s = 0; s < 4; s++) begin
      int t;
      logic h;
      if (n <= (1 << s)) continue;
      t = (s == 0) ? 8 : 11 + s;
      h = (a[16+s] & f64) ^ (a[21+s] & f2m) ^ (a[30+s] & f1g);
      if (s == 0 && one) h = h ^ a[14];
      a[t] = a[t] ^ h;
    end
    return a;
  endfunction

  logic          m_valid = 1'b0, m_err = 1'b0;
  logic [AW-1:0] m_addr = '0;
  logic          m_ready;
  assign m_ready = !m_valid || out_ready;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_valid <= 1'b0;
      m_err   <= 1'b0;
    end else if (in_valid && m_ready) begin
      logic b;
      m_addr  <= ref_fn(addr, e64, e2m, e1g, int'(cnt), sock, b);
      m_err   <= b;
      m_valid <= 1'b1;
    end else if (out_ready) begin
      m_valid <= 1'b0;
    end
  end

  task automatic chk(string req, logic [AW-1:0] got, logic [AW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic compare();
    chk("R8", AW'(out_valid), AW'(m_valid));
    chk("R9", AW'(in_ready), AW'(m_ready));
    if (m_valid) begin
      chk(tag, out_addr, m_addr);
      chk("R7", AW'(err), AW'(m_err));
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    compare();
  endtask

  task automatic send(string t, logic [AW-1:0] a, logic f64, logic f2m, logic f1g,
                      int n, logic one);
    cyc();
    tag = t;
    in_valid = 1'b1; addr = a; e64 = f64; e2m = f2m; e1g = f1g;
    cnt = CW'(n); sock = one;
    cyc();
    in_valid = 1'b0;
    cyc();
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) begin
      @(negedge clk);
      chk("R10", AW'({out_valid, err}), AW'(0));
    end
    rst_ni = 1'b1;

    send("R1", 52'h0_0001_0000, 1, 0, 0, 2, 0);
    send("R1", 52'h0_0020_0100, 0, 1, 0, 2, 0);
    send("R1", 52'h0_4000_0000, 0, 0, 1, 2, 0);
    send("R2", 52'h0_0000_4000, 0, 0, 0, 2, 1);
    send("R2", 52'h0_0000_4000, 0, 0, 0, 2, 0);
    send("R3", 52'h0_8042_0000, 1, 1, 1, 4, 0);
    send("R3", 52'h0_0002_0000, 1, 0, 0, 2, 0);
    send("R4", 52'h1_0084_0000, 1, 1, 1, 8, 0);
    send("R4", 52'h0_0004_0000, 1, 0, 0, 4, 0);
    send("R5", 52'h0_0008_4000, 1, 0, 0, 16, 1);
    send("R5", 52'h2_0100_0000, 0, 1, 1, 16, 0);
    send("R5", 52'h0_0008_4000, 1, 0, 0, 8, 1);
    send("R6", 52'hF_FFFF_FFFF_FFFF, 1, 1, 1, 16, 1);
    send("R7", 52'hF_FFFF_FFFF_FFFF, 1, 1, 1, 6, 1);
    send("R7", 52'h0_0001_0000, 1, 1, 1, 0, 0);
    send("R7", 52'h0_0001_0000, 1, 1, 1, 1, 0);
    send("R7", 52'h0_0001_0000, 1, 1, 1, 32 - 0, 0);

    // Stall: hold result while consumer not ready
    cyc();
    tag = "R9";
    addr = 52'h0_0021_0000; cnt = 5'd4; e64 = 1; e2m = 1; in_valid = 1'b1; out_ready = 1'b0;
    cyc();
    addr = 52'h0_0000_0000;
    repeat (4) cyc();
    out_ready = 1'b1;
    cyc();
    in_valid = 1'b0;
    cyc();

    // Random traffic with random backpressure
    tag = "R6";
    for (int i = 0; i < 2000; i++) begin
      int pick;
      cyc();
      in_valid  = ($urandom_range(0, 9) < 7);
      out_ready = ($urandom_range(0, 9) < 7);
      addr      = {$urandom(), $urandom()};
      e64 = 1'($urandom()); e2m = 1'($urandom()); e1g = 1'($urandom());
      sock = 1'($urandom());
      pick = $urandom_range(0, 9);
      cnt  = (pick < 8) ? CW'(2 << (pick % 4)) : CW'($urandom_range(0, 31));
    end
    in_valid = 1'b0; out_ready = 1'b1;
    repeat (3) cyc();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule